// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block holds the interrupt control state of a small processor core: the global interrupt-enable flag, one mask bit for each of three maskable request lines, the serial output bit, and the halted state. The core decodes its instructions and sends the block one-cycle pulses for enable, disable, halt, mask-read and mask-write. On a mask-write it also supplies the accumulator byte. The block samples the request lines, the non-maskable trap line and the serial input bit.

Among the requests that are allowed through, the block chooses one by fixed priority. It presents that request to the core with an identifier and holds it until the core acknowledges it. Every acknowledge clears the enable flag. A halted core stays stopped until an interrupt is acknowledged or reset is applied. A mask-read captures a status byte that holds the serial input, the pending lines, the enable flag and the masks. Vectoring, stacking and the core pipeline belong to the core.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While rst_ni is low, the block returns to this state: halted_o=0, irq_req_o=0, irq_id_o=0, rim_data_o=0, sod_o=0, interrupt enable 0 and all three masks 1.
- R2: An ei_i pulse sets the interrupt enable at the clock edge. A di_i pulse clears it. When both arrive in the same cycle, di_i wins. Neither pulse changes any other state.
- R3: An ack_i pulse clears the interrupt enable at that edge, even when ei_i is high in the same cycle.
- R4: An hlt_i pulse raises halted_o from the next cycle. halted_o then stays high until an ack_i edge clears it or reset is applied. Pulses of ei_i, di_i, rim_i and sim_i do not clear it.
- R5: A rim_i pulse captures rim_data_o = {sid_i, pend[2:0], ie, mask[2:0]}. Bit 7 is the serial input, bits 6:4 are the sampled request lines (bit 6 is line 2), bit 3 is the enable and bits 2:0 are the masks. rim_data_o keeps this value until the next rim_i pulse.
- R6: A sim_i pulse loads mask[2:0] from acc_i[2:0] only when acc_i[3]=1. When acc_i[3]=0, the masks keep their value.
- R7: A sim_i pulse loads sod_o from acc_i[7] only when acc_i[6]=1. When acc_i[6]=0, sod_o keeps its value.
- R8: Request line k is forwarded only when the enable is 1 and mask[k] is 0. A line raised at a clock edge is presented on irq_req_o after the second following edge.
- R9: A high trap_i is forwarded whatever the enable and mask state is, with irq_id_o=3.
- R10: Priority is trap (id 3), then line 2 (id 2), line 1 (id 1), line 0 (id 0). irq_id_o carries the winner.
- R11: Once irq_req_o is high, it and irq_id_o stay unchanged until ack_i, even if a higher-priority request arrives. The ack edge drops irq_req_o. A request that is still eligible is presented again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ei_i | input | 1 | Enable-interrupts pulse |
| di_i | input | 1 | Disable-interrupts pulse |
| hlt_i | input | 1 | Halt pulse |
| rim_i | input | 1 | Mask-read pulse |
| sim_i | input | 1 | Mask-write pulse |
| acc_i | input | 8 | Accumulator byte for mask-write |
| irq_i | input | 3 | Maskable request lines, index 2 highest |
| trap_i | input | 1 | Non-maskable trap request |
| sid_i | input | 1 | Serial data input bit |
| ack_i | input | 1 | Interrupt acknowledge pulse from the core |
| halted_o | output | 1 | Core is halted |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 2 | Identifier of the presented request |
| rim_data_o | output | 8 | Captured status byte |
| sod_o | output | 1 | Serial data output bit |

## Verification
The bench sweeps every combination of enable, mask, request lines and trap, and reads the status byte for each one. This catches a polarity error in the masks, a trap that depends on the enable, or an inverted priority order. Directed cases cover the conflicts. If ei won over di or over ack, software would see the enable still set. A design that re-arbitrated a held request would change irq_id_o when the trap arrived. A design that let halt clear on any control pulse would drop halted_o after ei. Mask-writes with the enable bits cleared must leave the masks and sod_o unchanged; a design that ignored those bits would overwrite them.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned ID_W      = 2;
  localparam int unsigned BYTE_W    = 8;
  // mask-write byte fields
  localparam int unsigned SIM_SOD_BIT  = 7;
  localparam int unsigned SIM_SOE_BIT  = 6;
  localparam int unsigned SIM_MSE_BIT  = 3;
  localparam logic [ID_W-1:0] TRAP_ID  = ID_W'(NUM_LINES);
endpackage

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_halt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ei_i,
  input  logic                 di_i,
  input  logic                 hlt_i,
  input  logic                 sim_i,
  input  logic                 ack_i,
  input  logic [BYTE_W-1:0]    acc_i,
  output logic                 ie_o,
  output logic [NUM_LINES-1:0] mask_o,
  output logic                 sod_o,
  output logic                 halted_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o <= 1'b0;
    end else if (ack_i || di_i) begin
      ie_o <= 1'b0;
    end else if (ei_i) begin
      ie_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '1;
      sod_o  <= 1'b0;
    end else if (sim_i) begin
      if (acc_i[SIM_MSE_BIT]) mask_o <= acc_i[NUM_LINES-1:0];
      if (acc_i[SIM_SOE_BIT]) sod_o  <= acc_i[SIM_SOD_BIT];
    end
  end

  // halt leaves only through an accepted interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_o <= 1'b0;
    end else if (ack_i) begin
      halted_o <= 1'b0;
    end else if (hlt_i) begin
      halted_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_halt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 trap_i,
  input  logic                 ie_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 ack_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 req_o,
  output logic [ID_W-1:0]      id_o
);
  logic                 trap_q;
  logic [NUM_LINES-1:0] elig;
  logic                 any_elig;
  logic [ID_W-1:0]      win_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      trap_q <= 1'b0;
    end else begin
      pend_o <= irq_i;
      trap_q <= trap_i;
    end
  end

  assign elig = pend_o & ~mask_i & {NUM_LINES{ie_i}};

  // higher index overrides lower; trap overrides all
  always_comb begin
    win_id   = '0;
    any_elig = 1'b0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (elig[k]) begin
        win_id   = ID_W'(k);
        any_elig = 1'b1;
      end
    end
    if (trap_q) begin
      win_id   = TRAP_ID;
      any_elig = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      id_o  <= '0;
    end else if (ack_i) begin
      req_o <= 1'b0;
    end else if (!req_o && any_elig) begin
      req_o <= 1'b1;
      id_o  <= win_id;
    end
  end
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irq_halt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ei_i,
  input  logic        di_i,
  input  logic        hlt_i,
  input  logic        rim_i,
  input  logic        sim_i,
  input  logic [7:0]  acc_i,
  input  logic [2:0]  irq_i,
  input  logic        trap_i,
  input  logic        sid_i,
  input  logic        ack_i,
  output logic        halted_o,
  output logic        irq_req_o,
  output logic [1:0]  irq_id_o,
  output logic [7:0]  rim_data_o,
  output logic        sod_o
);
  logic                 ie;
  logic [NUM_LINES-1:0] mask;
  logic [NUM_LINES-1:0] pend;

  irq_ctrl_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ei_i     (ei_i),
    .di_i     (di_i),
    .hlt_i    (hlt_i),
    .sim_i    (sim_i),
    .ack_i    (ack_i),
    .acc_i    (acc_i),
    .ie_o     (ie),
    .mask_o   (mask),
    .sod_o    (sod_o),
    .halted_o (halted_o)
  );

  irq_arbiter i_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .irq_i  (irq_i),
    .trap_i (trap_i),
    .ie_i   (ie),
    .mask_i (mask),
    .ack_i  (ack_i),
    .pend_o (pend),
    .req_o  (irq_req_o),
    .id_o   (irq_id_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rim_data_o <= '0;
    end else if (rim_i) begin
      rim_data_o <= {sid_i, pend, ie, mask};
    end
  end
endmodule

// File: rtl/irq_halt_chk.sv
module irq_halt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ei_i,
  input logic       di_i,
  input logic       hlt_i,
  input logic       sim_i,
  input logic       ack_i,
  input logic [7:0] acc_i,
  input logic       ie,
  input logic [2:0] mask,
  input logic       sod_o,
  input logic       halted_o,
  input logic       irq_req_o,
  input logic [1:0] irq_id_o
);
  p_ei_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !ack_i) |=> ie);
  p_di_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !ie);
  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ie);
  p_halt_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlt_i && !ack_i) |=> halted_o);
  p_halt_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_o) |-> $past(ack_i));
  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sim_i || !acc_i[3]) |=> $stable(mask));
  p_sod_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sim_i || !acc_i[6]) |=> $stable(sod_o));
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !ack_i) |=> (irq_req_o && $stable(irq_id_o)));
  p_req_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_req_o);
endmodule

bind irq_halt_ctrl irq_halt_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ei_i      (ei_i),
  .di_i      (di_i),
  .hlt_i     (hlt_i),
  .sim_i     (sim_i),
  .ack_i     (ack_i),
  .acc_i     (acc_i),
  .ie        (ie),
  .mask      (mask),
  .sod_o     (sod_o),
  .halted_o  (halted_o),
  .irq_req_o (irq_req_o),
  .irq_id_o  (irq_id_o)
);

// File: tb/test_irq_halt_ctrl.sv
module test_irq_halt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ei = 0, di = 0, hlt = 0, rim = 0, sim = 0, trap = 0, sid = 0, ack = 0;
  logic [7:0] acc = '0;
  logic [2:0] irq = '0;
  logic       halted, req, sod;
  logic [1:0] id;
  logic [7:0] rim_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_halt_ctrl i_irq_halt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ei_i(ei), .di_i(di), .hlt_i(hlt),
    .rim_i(rim), .sim_i(sim), .acc_i(acc), .irq_i(irq), .trap_i(trap),
    .sid_i(sid), .ack_i(ack), .halted_o(halted), .irq_req_o(req),
    .irq_id_o(id), .rim_data_o(rim_data), .sod_o(sod)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ei();  ei = 1;  tick(); ei = 0;  endtask
  task automatic do_di();  di = 1;  tick(); di = 0;  endtask
  task automatic do_ack(); ack = 1; tick(); ack = 0; endtask
  task automatic do_rim(); rim = 1; tick(); rim = 0; endtask
  task automatic do_sim(input logic [7:0] v); acc = v; sim = 1; tick(); sim = 0; acc = '0; endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 halted", halted, 0);
    chk("R1 req", req, 0);
    chk("R1 id", id, 0);
    chk("R1 rim", rim_data, 0);
    chk("R1 sod", sod, 0);
    rst_n = 1;
    tick();
    do_rim();
    chk("R1 ie/mask", rim_data, 8'h07);

    // R2: ei then di, and di beats ei
    do_ei(); do_rim();
    chk("R2 ei sets", rim_data[3], 1);
    ei = 1; di = 1; tick(); ei = 0; di = 0;
    do_rim();
    chk("R2 di wins", rim_data, 8'h07);

    // R3: ack beats ei
    do_ei();
    ei = 1; ack = 1; tick(); ei = 0; ack = 0;
    do_rim();
    chk("R3 ack wins", rim_data[3], 0);

    // R4 halt
    hlt = 1; tick(); hlt = 0;
    chk("R4 halted", halted, 1);
    do_ei(); do_di(); do_rim(); do_sim(8'h48);
    chk("R4 held", halted, 1);
    do_ack();
    chk("R4 exit by ack", halted, 0);
    do_sim(8'h0F); // restore masks 111

    // R6 mask-set enable
    do_sim(8'h08 | 8'h05);
    do_rim();
    chk("R6 load", rim_data[2:0], 3'b101);
    do_sim(8'h02);
    do_rim();
    chk("R6 ignore", rim_data[2:0], 3'b101);

    // R7 serial out
    do_sim(8'hC0);
    chk("R7 set", sod, 1);
    do_sim(8'h80 & 8'h00);
    do_sim(8'h00);
    chk("R7 ignore", sod, 1);
    do_sim(8'h40);
    chk("R7 clear", sod, 0);
    do_sim(8'h80);
    chk("R7 ignore2", sod, 0);

    // R8 R9 R10 R5 sweep
    for (int v = 0; v < 256; v++) begin
      logic       e_ie, e_tr, e_req;
      logic [2:0] e_mask, e_lin, el;
      logic [1:0] e_id;
      e_ie = v[7]; e_tr = v[6]; e_mask = v[5:3]; e_lin = v[2:0];
      do_sim({4'b0000, 1'b1, e_mask});
      if (e_ie) do_ei();
      irq = e_lin; trap = e_tr; sid = e_lin[0] ^ e_tr;
      el = e_lin & ~e_mask & {3{e_ie}};
      e_req = e_tr || (el != 0);
      e_id = e_tr ? 2'd3 : el[2] ? 2'd2 : el[1] ? 2'd1 : 2'd0;
      tick();
      chk("R8 latency", req, 0);
      tick();
      chk("R8 R9 req", req, e_req);
      if (e_req) chk("R10 id", id, e_id);
      do_rim();
      chk("R5 rim", rim_data, {sid, e_lin, e_ie, e_mask});
      irq = 0; trap = 0; sid = 0;
      do_ack();
      chk("R11 drop", req, 0);
      tick();
    end

    // R11 hold against higher priority, re-present after ack
    do_sim(8'h08);
    do_ei();
    irq = 3'b001;
    tick(); tick();
    chk("R11 line0", id, 0);
    trap = 1;
    tick(); tick(); tick();
    chk("R11 held req", req, 1);
    chk("R11 held id", id, 0);
    do_ack();
    chk("R11 ack drop", req, 0);
    tick();
    chk("R11 re-req", req, 1);
    chk("R11 re-id", id, 3);
    trap = 0; irq = 0;
    do_ack();

    finish_run();
  end
endmodule